// File: doc/BRIEF.md
# Exception Entry and Tail-Chain Sequencer

This block sequences the life of an exception handler with exact cycle counts. An external arbiter presents the most urgent pending exception (number and priority). When the sequencer is idle it accepts that exception and spends a fixed number of cycles saving the context frame. The memory traffic is modelled by a countdown only. It then pulses a handler-start strobe, which also clears the entered exception's pending flag in the arbiter.

The core signals the end of a handler with a one-cycle return strobe. If nothing is pending at that moment, the frame is restored over the same fixed number of cycles and the sequencer goes idle. If something is pending, the frame is left in place. Only a short vector fetch runs before the next handler starts, so the two handlers are chained without a restore and a new save between them.

While the frame is being saved, the entry target can still change. A strictly more urgent exception that arrives before the last save cycle takes over the entry, and the save runs on unchanged. The earlier exception stays pending and is chained in afterwards. The handler address is the table base plus four times the exception number. The table base comes from a writable register that is always aligned to 128 bytes. A source that is still asserted when its pending flag is cleared is re-pended by the arbiter, which lies outside this block.

Top module: `exc_seq`

## Requirements
- R1: After reset, stacking, unstacking, vec_req, handler_start and clr_valid are low, active_num is 0, and vec_addr is 0 (the table base resets to 0).
- R2: When idle and pend_valid is sampled high, stacking rises in the next cycle and stays high for exactly 12 cycles. handler_start pulses in the cycle after the last stacking cycle. From that cycle on, active_num holds the entered exception number.
- R3: While vec_req is high, vec_addr equals the table base plus 4 times the exception being fetched. With base 0, exception 16 (the first peripheral interrupt) is fetched from 0x40.
- R4: A cycle with base_we high loads base_wdata into the table base with bits [6:0] forced to 0.
- R5: ret_req sampled during a handler with pend_valid low makes unstacking rise in the next cycle and stay high for exactly 12 cycles. After that the block is idle and active_num is 0.
- R6: ret_req sampled during a handler with pend_valid high starts a 6-cycle vector fetch in the next cycle. During the fetch vec_req is high, stacking and unstacking stay low, and active_num keeps the old number. handler_start then pulses for the new exception in the following cycle.
- R7: During stacking, a pending exception with a strictly smaller priority value (smaller means more urgent) sampled on any stacking cycle except the last replaces the entry target. Stacking length is unchanged, and the replaced exception is tail-chained after the new one returns.
- R8: A pending exception sampled on the last stacking cycle, or one with an equal or larger priority value, does not replace the entry target.
- R9: clr_valid is a one-cycle pulse that coincides with handler_start, with clr_num equal to the entered exception number.
- R10: ret_req while no handler is running has no effect: no unstacking, stacking or handler_start follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pend_valid | input | 1 | Arbiter has a pending exception |
| pend_num | input | NUM_W | Number of the most urgent pending exception |
| pend_prio | input | PRIO_W | Its priority (smaller is more urgent) |
| ret_req | input | 1 | One-cycle return-from-handler strobe from the core |
| base_we | input | 1 | Write strobe for the vector table base |
| base_wdata | input | ADDR_W | New table base (low 7 bits ignored) |
| stacking | output | 1 | Context save in progress |
| unstacking | output | 1 | Context restore in progress |
| vec_req | output | 1 | Vector fetch in progress (during stacking or chaining) |
| vec_addr | output | ADDR_W | Address of the handler vector being fetched |
| active_num | output | NUM_W | Number of the running exception, 0 in thread mode |
| handler_start | output | 1 | One-cycle pulse when a handler begins |
| clr_valid | output | 1 | Pending-flag clear strobe to the arbiter |
| clr_num | output | NUM_W | Exception whose pending flag is cleared |

## Verification
A wrong phase counter shows as a stacking, unstacking or fetch window of the wrong width, so it is visible when that phase ends, at most 12 cycles after it starts. A corrupted entry target shows as a wrong active_num, clr_num or vec_addr at the next handler_start. A wrong choice between chaining and restoring shows in the cycle right after the return strobe, as unstacking where a fetch was due or the reverse. Late arrival is swept across early, next-to-last, last-cycle and equal-priority cases, because the swap window differs from the wrong one by a single cycle.

// File: rtl/exc_seq_pkg.sv
// Package: shared types for the exception entry sequencer.
// Assumes: one phase is active at a time; encoding is free.
package exc_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_STACK,
        PH_RUN,
        PH_CHAIN,
        PH_UNSTACK
    } phase_e;

endpackage

// File: rtl/exc_seq_timer.sv
// Module: exc_seq_timer
// Down-counter that times one sequencer phase. A load sets the count to
// (phase length - 1); zero flags the last cycle of the phase.
// Assumes: load is only asserted when a phase begins.
module exc_seq_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);

    logic [CW-1:0] cnt_q;

    // Count down the current phase, holding at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load)           cnt_q <= load_val;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/exc_seq_vbase.sv
// Module: exc_seq_vbase
// Holds the vector table base (forced to BASE_LSB-bit alignment) and forms
// the handler vector address as base + 4 * exception number.
// Assumes: writes may happen at any time and take effect the next cycle.
module exc_seq_vbase #(
    parameter int ADDR_W   = 32,
    parameter int NUM_W    = 9,
    parameter int BASE_LSB = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] wdata,
    input  logic [NUM_W-1:0]  num,
    output logic [ADDR_W-1:0] addr
);

    localparam logic [ADDR_W-1:0] KEEP = ~((ADDR_W'(1) << BASE_LSB) - ADDR_W'(1));

    logic [ADDR_W-1:0] base_q;

    // Table base register with the alignment bits cleared.
    always_ff @(posedge clk) begin
        if (!rst_n)  base_q <= '0;
        else if (we) base_q <= wdata & KEEP;
    end

    // Vector address: one word per exception number.
    assign addr = base_q + (ADDR_W'(num) << 2);

endmodule

// File: rtl/exc_seq.sv
// Module: exc_seq (top)
// Cycle-counted exception entry, return and tail-chain sequencer.
// Idle -> stack (STACK_CYC) -> run -> either unstack (STACK_CYC) -> idle,
// or chain (CHAIN_CYC vector fetch) -> run. A strictly more urgent arrival
// replaces the entry target on any stacking cycle but the last.
// Assumes: the arbiter keeps pend_* pointing at its most urgent pending
// exception and clears that flag on clr_valid; ret_req is a 1-cycle strobe;
// no nesting while a handler runs.
module exc_seq
    import exc_seq_pkg::*;
#(
    parameter int NUM_W     = 9,
    parameter int PRIO_W    = 4,
    parameter int ADDR_W    = 32,
    parameter int BASE_LSB  = 7,
    parameter int STACK_CYC = 12,
    parameter int CHAIN_CYC = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pend_valid,
    input  logic [NUM_W-1:0]  pend_num,
    input  logic [PRIO_W-1:0] pend_prio,
    input  logic              ret_req,
    input  logic              base_we,
    input  logic [ADDR_W-1:0] base_wdata,
    output logic              stacking,
    output logic              unstacking,
    output logic              vec_req,
    output logic [ADDR_W-1:0] vec_addr,
    output logic [NUM_W-1:0]  active_num,
    output logic              handler_start,
    output logic              clr_valid,
    output logic [NUM_W-1:0]  clr_num
);

    localparam int MAXC = (STACK_CYC > CHAIN_CYC) ? STACK_CYC : CHAIN_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    phase_e            ph_q;
    logic [NUM_W-1:0]  tgt_num_q;
    logic [PRIO_W-1:0] tgt_prio_q;
    logic [NUM_W-1:0]  act_q;
    logic              hs_q;
    logic              tm_load;
    logic [CW-1:0]     tm_val;
    logic              tm_zero;
    logic              late_win;

    // A more urgent arrival may still take over, but not on the last save cycle.
    assign late_win = (ph_q == PH_STACK) && !tm_zero && pend_valid &&
                      (pend_prio < tgt_prio_q);

    // Start the phase timer when a save, restore or chain fetch begins.
    always_comb begin
        tm_load = 1'b0;
        tm_val  = CW'(STACK_CYC - 1);
        if (ph_q == PH_IDLE && pend_valid) begin
            tm_load = 1'b1;
        end else if (ph_q == PH_RUN && ret_req) begin
            tm_load = 1'b1;
            if (pend_valid) tm_val = CW'(CHAIN_CYC - 1);
        end
    end

    exc_seq_timer #(.CW(CW)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tm_load),
        .load_val (tm_val),
        .zero     (tm_zero)
    );

    exc_seq_vbase #(.ADDR_W(ADDR_W), .NUM_W(NUM_W), .BASE_LSB(BASE_LSB)) vbase_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (base_we),
        .wdata (base_wdata),
        .num   (tgt_num_q),
        .addr  (vec_addr)
    );

    // Phase sequencing, entry target tracking and handler-start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q       <= PH_IDLE;
            tgt_num_q  <= '0;
            tgt_prio_q <= '0;
            act_q      <= '0;
            hs_q       <= 1'b0;
        end else begin
            hs_q <= 1'b0;
            unique case (ph_q)
                PH_IDLE: begin
                    if (pend_valid) begin
                        ph_q       <= PH_STACK;
                        tgt_num_q  <= pend_num;
                        tgt_prio_q <= pend_prio;
                    end
                end
                PH_STACK: begin
                    if (tm_zero) begin
                        ph_q  <= PH_RUN;
                        hs_q  <= 1'b1;
                        act_q <= tgt_num_q;
                    end else if (late_win) begin
                        tgt_num_q  <= pend_num;
                        tgt_prio_q <= pend_prio;
                    end
                end
                PH_RUN: begin
                    if (ret_req) begin
                        if (pend_valid) begin
                            ph_q       <= PH_CHAIN;
                            tgt_num_q  <= pend_num;
                            tgt_prio_q <= pend_prio;
                        end else begin
                            ph_q <= PH_UNSTACK;
                        end
                    end
                end
                PH_CHAIN: begin
                    if (tm_zero) begin
                        ph_q  <= PH_RUN;
                        hs_q  <= 1'b1;
                        act_q <= tgt_num_q;
                    end
                end
                PH_UNSTACK: begin
                    if (tm_zero) begin
                        ph_q  <= PH_IDLE;
                        act_q <= '0;
                    end
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    // Port views of the phase and handler state.
    assign stacking      = (ph_q == PH_STACK);
    assign unstacking    = (ph_q == PH_UNSTACK);
    assign vec_req       = (ph_q == PH_STACK) || (ph_q == PH_CHAIN);
    assign active_num    = act_q;
    assign handler_start = hs_q;
    assign clr_valid     = hs_q;
    assign clr_num       = act_q;

    // R2: a save always ends by starting a handler.
    a_r2_stack_ends_in_handler : assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stacking) |-> handler_start);

    // R5: a return with nothing pending begins a restore.
    a_r5_return_restores : assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_RUN && ret_req && !pend_valid) |=> unstacking);

    // R6: a return with work pending neither restores nor saves again.
    a_r6_chain_skips_frame : assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_RUN && ret_req && pend_valid) |=> (!unstacking && !stacking && vec_req));

    // R8: the entry target is frozen on the last save cycle.
    a_r8_no_swap_last_cycle : assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_STACK && tm_zero) |=> $stable(tgt_num_q));

    // R9: the start strobe lasts a single cycle.
    a_r9_start_pulse : assert property (@(posedge clk) disable iff (!rst_n)
        handler_start |=> !handler_start);

endmodule

// File: tb/exc_seq_tb_top.sv
module exc_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        pend_valid;
    logic [8:0]  pend_num;
    logic [3:0]  pend_prio;
    logic        ret_req;
    logic        base_we;
    logic [31:0] base_wdata;
    logic        stacking, unstacking, vec_req, handler_start, clr_valid;
    logic [31:0] vec_addr;
    logic [8:0]  active_num, clr_num;

    always #5 clk = ~clk;

    exc_seq dut_i (
        .clk(clk), .rst_n(rst_n), .pend_valid(pend_valid), .pend_num(pend_num),
        .pend_prio(pend_prio), .ret_req(ret_req), .base_we(base_we),
        .base_wdata(base_wdata), .stacking(stacking), .unstacking(unstacking),
        .vec_req(vec_req), .vec_addr(vec_addr), .active_num(active_num),
        .handler_start(handler_start), .clr_valid(clr_valid), .clr_num(clr_num)
    );

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Arbiter model: pending bits, priorities, held sources.
    logic       pnd [32];
    logic       src [32];
    logic [3:0] pr  [32];

    always_comb begin
        pend_valid = 1'b0;
        pend_num   = '0;
        pend_prio  = '1;
        for (int n = 0; n < 32; n++) begin
            if (pnd[n] && (!pend_valid || pr[n] < pend_prio)) begin
                pend_valid = 1'b1;
                pend_num   = 9'(n);
                pend_prio  = pr[n];
            end
        end
    end

    always @(posedge clk) begin
        for (int n = 0; n < 32; n++) begin
            if (clr_valid && clr_num == 9'(n)) pnd[n] <= 1'b0;
            else if (src[n])                  pnd[n] <= 1'b1;
        end
    end

    // Port monitor: phase widths, handler starts, clear strobe (R9).
    logic prev_stk = 0, prev_unstk = 0, prev_chn = 0;
    int stk_start, stk_len, stk_eps, unstk_start, unstk_len, unstk_eps;
    int chn_start, chn_len, chn_eps, hs_cnt;
    int hs_num [8];
    int hs_cyc [8];
    longint hs_addr [8];
    longint last_addr;

    always @(negedge clk) begin
        if (rst_n) begin
            if (stacking && !prev_stk) begin stk_start = cyc; stk_eps++; end
            if (!stacking && prev_stk) stk_len = cyc - stk_start;
            if (unstacking && !prev_unstk) begin unstk_start = cyc; unstk_eps++; end
            if (!unstacking && prev_unstk) unstk_len = cyc - unstk_start;
            if ((vec_req && !stacking) && !prev_chn) begin chn_start = cyc; chn_eps++; end
            if (!(vec_req && !stacking) && prev_chn) chn_len = cyc - chn_start;
            if (vec_req && !stacking && hs_cnt > 0)
                chk("R6", "active_num held during fetch", active_num, hs_num[hs_cnt-1]);
            if (vec_req) last_addr = vec_addr;
            if (handler_start) begin
                chk("R9", "clr_valid with start", clr_valid, 1);
                chk("R9", "clr_num", clr_num, active_num);
                if (hs_cnt < 8) begin
                    hs_num[hs_cnt]  = active_num;
                    hs_cyc[hs_cnt]  = cyc;
                    hs_addr[hs_cnt] = last_addr;
                end
                hs_cnt++;
            end else if (clr_valid) begin
                chk("R9", "clr_valid without start", clr_valid, 0);
            end
        end
        prev_stk   = stacking;
        prev_unstk = unstacking;
        prev_chn   = vec_req && !stacking;
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic clear_log();
        stk_eps = 0; unstk_eps = 0; chn_eps = 0; hs_cnt = 0;
        stk_len = 0; unstk_len = 0; chn_len = 0;
    endtask

    task automatic raise(input int n, input logic [3:0] p, input logic hold);
        pr[n]  = p;
        pnd[n] = 1'b1;
        src[n] = hold;
    endtask

    int ret_cyc;
    task automatic ret_pulse();
        ret_req = 1'b1;
        ret_cyc = cyc;
        step();
        ret_req = 1'b0;
    endtask

    task automatic wait_hs(input int k);
        while (hs_cnt < k) step();
    endtask

    task automatic wait_stack_idx(input int k);
        while (!stacking) step();
        repeat (k - 1) step();
    endtask

    task automatic write_base(input logic [31:0] b);
        base_we    = 1'b1;
        base_wdata = b;
        step();
        base_we    = 1'b0;
    endtask

    // Single entry/return, 12 + 12 cycles.
    task automatic run_single(input int n, input logic [3:0] p, input longint exp_addr, input string areq);
        int r;
        clear_log();
        raise(n, p, 1'b0);
        r = cyc;
        wait_hs(1);
        repeat (3) step();
        ret_pulse();
        repeat (16) step();
        chk("R2", "stacking start", stk_start, r + 1);
        chk("R2", "stacking length", stk_len, 12);
        chk("R2", "start after save", hs_cyc[0] - stk_start, 12);
        chk("R2", "entered number", hs_num[0], n);
        chk(areq, "vector address", hs_addr[0], exp_addr);
        chk("R5", "unstacking start", unstk_start, ret_cyc + 1);
        chk("R5", "unstacking length", unstk_len, 12);
        chk("R6", "no fetch-only phase", chn_eps, 0);
        chk("R5", "active_num idle", active_num, 0);
    endtask

    // Late arrival at stacking cycle k; expect first/second handler numbers.
    task automatic run_late(input int k, input int n0, input logic [3:0] p0,
                            input int n1, input logic [3:0] p1,
                            input int first, input int second, input string req);
        clear_log();
        raise(n0, p0, 1'b0);
        wait_stack_idx(k);
        raise(n1, p1, 1'b0);
        wait_hs(1);
        step();
        ret_pulse();
        wait_hs(2);
        step();
        ret_pulse();
        repeat (16) step();
        chk(req, "first handler", hs_num[0], first);
        chk(req, "second handler", hs_num[1], second);
        chk(req, "stacking length unchanged", stk_len, 12);
        chk(req, "single save", stk_eps, 1);
        chk("R6", "chained fetch length", chn_len, 6);
        chk("R5", "single restore", unstk_eps, 1);
    endtask

    initial begin
        for (int n = 0; n < 32; n++) begin pnd[n] = 0; src[n] = 0; pr[n] = '1; end
        rst_n = 1'b0; ret_req = 1'b0; base_we = 1'b0; base_wdata = '0;
        clear_log();
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1: reset state
        chk("R1", "stacking", stacking, 0);
        chk("R1", "unstacking", unstacking, 0);
        chk("R1", "vec_req", vec_req, 0);
        chk("R1", "handler_start", handler_start, 0);
        chk("R1", "clr_valid", clr_valid, 0);
        chk("R1", "active_num", active_num, 0);
        chk("R1", "vec_addr", vec_addr, 0);

        // R10: return strobe with no handler running
        clear_log();
        ret_pulse();
        repeat (4) step();
        chk("R10", "no restore", unstk_eps, 0);
        chk("R10", "no save", stk_eps, 0);
        chk("R10", "no start", hs_cnt, 0);

        // R2 R3 R5: first peripheral interrupt at base 0 -> 0x40
        run_single(16, 4'd5, 64'h40, "R3");

        // R4: base alignment, then sweep every number 16..31
        write_base(32'h2000_00FF);
        run_single(20, 4'd2, 64'h2000_00D0, "R4");
        for (int n = 16; n < 32; n++) begin
            logic [31:0] b;
            b = 32'h1000_0000 + 32'(n) * 32'h1357;
            write_base(b);
            run_single(n, 4'(n % 16), longint'(b & 32'hFFFF_FF80) + 4 * n, "R4");
        end
        write_base(32'h0);

        // R6: chained pair, 12 + 6 + 12
        clear_log();
        raise(17, 4'd3, 1'b0);
        raise(18, 4'd6, 1'b0);
        wait_hs(1);
        repeat (2) step();
        ret_pulse();
        wait_hs(2);
        chk("R6", "fetch start", chn_start, ret_cyc + 1);
        chk("R6", "fetch length", chn_len, 6);
        chk("R6", "start after return", hs_cyc[1] - ret_cyc, 7);
        chk("R6", "no restore between", unstk_eps, 0);
        chk("R6", "chained number", hs_num[1], 18);
        chk("R3", "chained vector", hs_addr[1], 18 * 4);
        step();
        ret_pulse();
        repeat (16) step();
        chk("R6", "first handler", hs_num[0], 17);
        chk("R5", "final restore length", unstk_len, 12);

        // R7: late arrivals early and on the next-to-last cycle
        run_late(5,  19, 4'd8, 21, 4'd2, 21, 19, "R7");
        run_late(11, 19, 4'd8, 22, 4'd1, 22, 19, "R7");
        // R8: on the last cycle, and with equal priority
        run_late(12, 19, 4'd8, 22, 4'd1, 19, 22, "R8");
        run_late(5,  23, 4'd8, 19, 4'd8, 23, 19, "R8");

        // R9: held source re-pends after the clear and is chained again
        clear_log();
        raise(24, 4'd4, 1'b1);
        wait_hs(1);
        repeat (3) step();
        ret_pulse();
        wait_hs(2);
        src[24] = 1'b0;
        step();
        ret_pulse();
        repeat (16) step();
        chk("R9", "re-entered same number", hs_num[1], 24);
        chk("R9", "chained once", chn_eps, 1);
        chk("R9", "restored once", unstk_eps, 1);
        chk("R9", "no third entry", hs_cnt, 2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule